// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host two 32-bit ports into a small bank of device configuration registers. The host writes a register number to the select port, then reads or writes the value port to reach that register. The bank holds a version identifier, a mode enable, a command-consumption go flag, the display width and height, the pixel depth, a capability vector, the derived line pitch and visible framebuffer offset, the command-ring base and size, and the maximum width and height.

The block carries out a version handshake. The host writes the highest version it knows to the identifier register and reads it back. It lowers its offer until the value read back matches the value written. Only after a version other than the legacy one has been accepted does the block reveal the command-ring location. The pixel depth can be written only when the capability vector advertises 8-bit emulation, and even then only two depths are accepted. The line pitch and the framebuffer offset are recomputed from the current width and depth. The enable and go flags leave the block as outputs for the rest of the device.

Top module: `idx_cfg_port`

## Requirements
- R1: Pulsing `val_rd` returns the contents of the register selected by the last select-port write on `val_rdata` with `rd_valid` high exactly one cycle later. `rd_valid` is low in every cycle that does not follow a read pulse. The selection persists until the select port is written again.
- R2: Pulsing `val_wr` writes `val_wdata` to the selected register, subject to the rules of that register. Register numbers: 0 identifier, 1 enable, 2 width, 3 height, 4 depth, 5 host depth, 6 capabilities, 7 pitch, 8 framebuffer offset, 9 ring base, 10 ring size, 11 go flag, 12 max width, 13 max height.
- R3: Supported identifiers are `ID_BASE + n` for n = 0..`MAX_VER` (defaults 0x5A1D0000 and 2). A write of a supported identifier is stored. Any other write leaves the previous identifier in place, so the read-back differs from the value written.
- R4: The depth register is read-only unless capability bit `EMU_BIT` (default 1) of `cap_vec` is set. When it is writable, only the values 8 and `HOST_BPP` (default 32) are stored, and any other value is dropped.
- R5: Writing the enable register stores bit 0 of the data and drives it on `mode_en`. A 0 selects legacy behaviour.
- R6: Writing the go register stores bit 0 of the data and drives it on `cfg_done`. A 0 halts command consumption until a 1 is written.
- R7: Pitch reads width × (depth / 8). The framebuffer offset reads pitch × `TOP_LINES` (default 2). Both follow any width or depth change in time for the next read.
- R8: A width write above `MAX_W` (default 2048) or a height write above `MAX_H` (default 1536) is ignored.
- R9: Ring base and ring size read 0 until a supported identifier other than `ID_BASE` has been written. Writing `ID_BASE` hides them again.
- R10: Reading a register number above 13 returns 0. Writing one changes no register.
- R11: After reset the selection is 0, the identifier is `ID_BASE + MAX_VER`, enable and go are 0, width is 640, height is 480, and depth is `HOST_BPP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_wr | input | 1 | Write strobe of the select port |
| idx_wdata | input | 32 | Register number to select |
| val_wr | input | 1 | Write strobe of the value port |
| val_rd | input | 1 | Read strobe of the value port |
| val_wdata | input | 32 | Data written through the value port |
| cap_vec | input | 32 | Capability vector supplied by the device |
| val_rdata | output | 32 | Data returned through the value port |
| rd_valid | output | 1 | Marks `val_rdata` as holding a read result |
| mode_en | output | 1 | New mode enabled (0 = legacy) |
| cfg_done | output | 1 | Command consumption allowed |

## Verification
The handshake is tried with an identifier above the supported range, with one inside it, and with the legacy identifier. Together these separate storing the value, keeping the old one, and gating the ring registers. Depth writes are made with the capability bit clear and then set, using a legal and an illegal value each time, which separates read-only behaviour from value filtering. Width changes and depth changes are each followed by pitch and offset reads to show that the derived values track both inputs. Out-of-range sizes and unimplemented register numbers are then written and read back to show that nothing moved.

// File: rtl/idxcfg_pkg.sv
// Shared register numbering for the indexed configuration port.
// Assumes a flat 32-bit register number space; numbers above REG_LAST are unimplemented.
package idxcfg_pkg;
    localparam logic [31:0] REG_ID      = 32'd0;
    localparam logic [31:0] REG_ENABLE  = 32'd1;
    localparam logic [31:0] REG_WIDTH   = 32'd2;
    localparam logic [31:0] REG_HEIGHT  = 32'd3;
    localparam logic [31:0] REG_BPP     = 32'd4;
    localparam logic [31:0] REG_HBPP    = 32'd5;
    localparam logic [31:0] REG_CAPS    = 32'd6;
    localparam logic [31:0] REG_PITCH   = 32'd7;
    localparam logic [31:0] REG_FBOFS   = 32'd8;
    localparam logic [31:0] REG_RBASE   = 32'd9;
    localparam logic [31:0] REG_RSIZE   = 32'd10;
    localparam logic [31:0] REG_GO      = 32'd11;
    localparam logic [31:0] REG_MAXW    = 32'd12;
    localparam logic [31:0] REG_MAXH    = 32'd13;
    localparam logic [31:0] REG_LAST    = REG_MAXH;

    // Mode state seen by the read path.
    typedef struct packed {
        logic [31:0] width;
        logic [31:0] height;
        logic [31:0] bpp;
        logic [31:0] pitch;
        logic [31:0] fbofs;
    } mode_view_t;
endpackage

// File: rtl/idxcfg_version.sv
// Version handshake register.
// Stores a written identifier only when it lies in the supported range, and
// tracks whether a non-legacy identifier has been accepted.
// Assumes ID_BASE + MAX_VER does not wrap around 32 bits.
module idxcfg_version #(
    parameter logic [31:0] ID_BASE = 32'h5A1D_0000,
    parameter int unsigned MAX_VER = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] id_q,
    output logic        ext_ok
);
    localparam logic [31:0] ID_TOP = ID_BASE + 32'(MAX_VER);

    logic in_range;

    // Range check of the offered identifier.
    always_comb in_range = (wdata >= ID_BASE) && (wdata <= ID_TOP);

    // Identifier storage and extended-feature flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= ID_TOP;
            ext_ok <= 1'b0;
        end else if (wr_en && in_range) begin
            id_q   <= wdata;
            ext_ok <= (wdata != ID_BASE);
        end
    end
endmodule

// File: rtl/idxcfg_mode.sv
// Display mode registers: width, height, depth, and the derived pitch and offset.
// Width and height writes beyond the limits are dropped. The depth is writable only
// with the emulation capability, and then only 8 or HOST_BPP is stored.
// Derived values settle one cycle after the inputs change.
module idxcfg_mode #(
    parameter int unsigned HOST_BPP  = 32,
    parameter int unsigned MAX_W     = 2048,
    parameter int unsigned MAX_H     = 1536,
    parameter int unsigned DEF_W     = 640,
    parameter int unsigned DEF_H     = 480,
    parameter int unsigned TOP_LINES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_w,
    input  logic                      wr_h,
    input  logic                      wr_bpp,
    input  logic                      cap_emu,
    input  logic [31:0]               wdata,
    output idxcfg_pkg::mode_view_t    view
);
    localparam logic [31:0] HBPP_L  = 32'(HOST_BPP);
    localparam logic [31:0] PITCH_R = 32'(DEF_W * (HOST_BPP / 8));
    localparam logic [31:0] OFS_R   = 32'(DEF_W * (HOST_BPP / 8) * TOP_LINES);

    logic [31:0] width_q, height_q, bpp_q, pitch_q, ofs_q;
    logic        bpp_ok;

    // Depth write acceptance.
    always_comb bpp_ok = cap_emu && ((wdata == 32'd8) || (wdata == HBPP_L));

    // Primary mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= 32'(DEF_W);
            height_q <= 32'(DEF_H);
            bpp_q    <= HBPP_L;
        end else begin
            if (wr_w && (wdata <= 32'(MAX_W)))  width_q  <= wdata;
            if (wr_h && (wdata <= 32'(MAX_H)))  height_q <= wdata;
            if (wr_bpp && bpp_ok)               bpp_q    <= wdata;
        end
    end

    // Derived pitch and visible offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pitch_q <= PITCH_R;
            ofs_q   <= OFS_R;
        end else begin
            pitch_q <= width_q * {3'b000, bpp_q[31:3]};
            ofs_q   <= width_q * {3'b000, bpp_q[31:3]} * 32'(TOP_LINES);
        end
    end

    // Bundle for the read path.
    always_comb begin
        view.width  = width_q;
        view.height = height_q;
        view.bpp    = bpp_q;
        view.pitch  = pitch_q;
        view.fbofs  = ofs_q;
    end
endmodule

// File: rtl/idxcfg_ctrl.sv
// Register selection and the two control flags (mode enable, go).
// Assumes the flags take bit 0 of the written data.
module idxcfg_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idx_wr,
    input  logic [31:0] idx_wdata,
    input  logic        wr_en_reg,
    input  logic        wr_go_reg,
    input  logic        bit0,
    output logic [31:0] idx_q,
    output logic        en_q,
    output logic        go_q
);
    // Current register selection.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= idx_wdata;
    end

    // Enable and go flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            go_q <= 1'b0;
        end else begin
            if (wr_en_reg) en_q <= bit0;
            if (wr_go_reg) go_q <= bit0;
        end
    end
endmodule

// File: rtl/idx_cfg_port.sv
// Top of the indexed configuration port: decodes value-port writes against the
// selected register number and returns a registered read one cycle after val_rd.
// Assumes val_wr and val_rd are never asserted in the same cycle.
module idx_cfg_port #(
    parameter logic [31:0] ID_BASE    = 32'h5A1D_0000,
    parameter int unsigned MAX_VER    = 2,
    parameter int unsigned HOST_BPP   = 32,
    parameter int unsigned EMU_BIT    = 1,
    parameter int unsigned MAX_W      = 2048,
    parameter int unsigned MAX_H      = 1536,
    parameter int unsigned TOP_LINES  = 2,
    parameter logic [31:0] RING_BASE  = 32'h0010_0000,
    parameter logic [31:0] RING_SIZE  = 32'h0004_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idx_wr,
    input  logic [31:0] idx_wdata,
    input  logic        val_wr,
    input  logic        val_rd,
    input  logic [31:0] val_wdata,
    input  logic [31:0] cap_vec,
    output logic [31:0] val_rdata,
    output logic        rd_valid,
    output logic        mode_en,
    output logic        cfg_done
);
    import idxcfg_pkg::*;

    logic [31:0] idx_q;
    logic [31:0] id_q;
    logic        ext_ok;
    mode_view_t  view;
    logic [31:0] rd_mux;
    logic        hit_id, hit_en, hit_w, hit_h, hit_bpp, hit_go;

    // Write decode against the selected register.
    always_comb begin
        hit_id  = val_wr && (idx_q == REG_ID);
        hit_en  = val_wr && (idx_q == REG_ENABLE);
        hit_w   = val_wr && (idx_q == REG_WIDTH);
        hit_h   = val_wr && (idx_q == REG_HEIGHT);
        hit_bpp = val_wr && (idx_q == REG_BPP);
        hit_go  = val_wr && (idx_q == REG_GO);
    end

    idxcfg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_wdata (idx_wdata),
        .wr_en_reg (hit_en),
        .wr_go_reg (hit_go),
        .bit0      (val_wdata[0]),
        .idx_q     (idx_q),
        .en_q      (mode_en),
        .go_q      (cfg_done)
    );

    idxcfg_version #(.ID_BASE(ID_BASE), .MAX_VER(MAX_VER)) u_ver (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hit_id),
        .wdata  (val_wdata),
        .id_q   (id_q),
        .ext_ok (ext_ok)
    );

    idxcfg_mode #(
        .HOST_BPP  (HOST_BPP),
        .MAX_W     (MAX_W),
        .MAX_H     (MAX_H),
        .DEF_W     (640),
        .DEF_H     (480),
        .TOP_LINES (TOP_LINES)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_w    (hit_w),
        .wr_h    (hit_h),
        .wr_bpp  (hit_bpp),
        .cap_emu (cap_vec[EMU_BIT]),
        .wdata   (val_wdata),
        .view    (view)
    );

    // Read multiplexer over the register bank.
    always_comb begin
        case (idx_q)
            REG_ID:     rd_mux = id_q;
            REG_ENABLE: rd_mux = {31'd0, mode_en};
            REG_WIDTH:  rd_mux = view.width;
            REG_HEIGHT: rd_mux = view.height;
            REG_BPP:    rd_mux = view.bpp;
            REG_HBPP:   rd_mux = 32'(HOST_BPP);
            REG_CAPS:   rd_mux = cap_vec;
            REG_PITCH:  rd_mux = view.pitch;
            REG_FBOFS:  rd_mux = view.fbofs;
            REG_RBASE:  rd_mux = ext_ok ? RING_BASE : '0;
            REG_RSIZE:  rd_mux = ext_ok ? RING_SIZE : '0;
            REG_GO:     rd_mux = {31'd0, cfg_done};
            REG_MAXW:   rd_mux = 32'(MAX_W);
            REG_MAXH:   rd_mux = 32'(MAX_H);
            default:    rd_mux = '0;
        endcase
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_rdata <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= val_rd;
            if (val_rd) val_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/idxcfg_chk.sv
// Property checker for idx_cfg_port, attached by bind below.
// Assumes the register numbering of idxcfg_pkg.
module idxcfg_chk #(
    parameter logic [31:0] ID_BASE  = 32'h5A1D_0000,
    parameter int unsigned MAX_VER  = 2,
    parameter int unsigned HOST_BPP = 32,
    parameter int unsigned EMU_BIT  = 1,
    parameter int unsigned MAX_W    = 2048,
    parameter int unsigned MAX_H    = 1536
) (
    input logic        clk,
    input logic        rst_n,
    input logic        val_wr,
    input logic        val_rd,
    input logic [31:0] val_wdata,
    input logic [31:0] cap_vec,
    input logic [31:0] val_rdata,
    input logic        rd_valid,
    input logic        mode_en,
    input logic        cfg_done,
    input logic [31:0] idx_q,
    input logic [31:0] id_q,
    input logic        ext_ok,
    input logic [31:0] bpp_now,
    input logic [31:0] width_now,
    input logic [31:0] height_now
);
    import idxcfg_pkg::*;
    localparam logic [31:0] ID_TOP = ID_BASE + 32'(MAX_VER);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        val_rd |=> rd_valid); // R1
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !val_rd |=> !rd_valid); // R1
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_q >= ID_BASE) && (id_q <= ID_TOP)); // R3
    AST_ID_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && idx_q == REG_ID && (val_wdata < ID_BASE || val_wdata > ID_TOP)) |=> $stable(id_q)); // R3
    AST_BPP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && idx_q == REG_BPP && !cap_vec[EMU_BIT]) |=> $stable(bpp_now)); // R4
    AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bpp_now == 32'd8) || (bpp_now == 32'(HOST_BPP))); // R4
    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && idx_q == REG_ENABLE) |=> (mode_en == $past(val_wdata[0]))); // R5
    AST_GO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && idx_q == REG_GO) |=> (cfg_done == $past(val_wdata[0]))); // R6
    AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (width_now <= 32'(MAX_W)) && (height_now <= 32'(MAX_H))); // R8
    AST_RING_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (val_rd && !ext_ok && (idx_q == REG_RBASE || idx_q == REG_RSIZE)) |=> (val_rdata == 32'd0)); // R9
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (val_rd && idx_q > REG_LAST) |=> (val_rdata == 32'd0)); // R10
endmodule

bind idx_cfg_port idxcfg_chk #(
    .ID_BASE  (ID_BASE),
    .MAX_VER  (MAX_VER),
    .HOST_BPP (HOST_BPP),
    .EMU_BIT  (EMU_BIT),
    .MAX_W    (MAX_W),
    .MAX_H    (MAX_H)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .val_wr     (val_wr),
    .val_rd     (val_rd),
    .val_wdata  (val_wdata),
    .cap_vec    (cap_vec),
    .val_rdata  (val_rdata),
    .rd_valid   (rd_valid),
    .mode_en    (mode_en),
    .cfg_done   (cfg_done),
    .idx_q      (idx_q),
    .id_q       (id_q),
    .ext_ok     (ext_ok),
    .bpp_now    (view.bpp),
    .width_now  (view.width),
    .height_now (view.height)
);

// File: tb/sim_idx_cfg_port.sv
// Scoreboard bench: read tasks queue expected values, a monitor compares results.
module sim_idx_cfg_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IDB = 32'h5A1D_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0;
    logic [31:0] idx_wdata = '0;
    logic        val_wr = 1'b0;
    logic        val_rd = 1'b0;
    logic [31:0] val_wdata = '0;
    logic [31:0] cap_vec = '0;
    logic [31:0] val_rdata;
    logic        rd_valid;
    logic        mode_en;
    logic        cfg_done;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        done = 1'b0;

    idx_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .val_wr(val_wr), .val_rd(val_rd), .val_wdata(val_wdata), .cap_vec(cap_vec),
        .val_rdata(val_rdata), .rd_valid(rd_valid), .mode_en(mode_en), .cfg_done(cfg_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sel(input logic [31:0] ix);
        @(negedge clk);
        idx_wr = 1'b1; idx_wdata = ix;
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    task automatic wr(input logic [31:0] ix, input logic [31:0] d);
        sel(ix);
        val_wr = 1'b1; val_wdata = d;
        @(negedge clk);
        val_wr = 1'b0;
    endtask

    // Read of the current selection; result expected on the next negedge.
    task automatic rd_cur(input logic [31:0] exp, input string tag);
        @(negedge clk);
        val_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        val_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [31:0] ix, input logic [31:0] exp, input string tag);
        sel(ix);
        rd_cur(exp, tag);
    endtask

    // Monitor: compares each returned read, and flags reads nobody issued.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), val_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state, index resets to 0 so a bare read returns the identifier
        check("R11 mode_en reset", {31'd0, mode_en}, 32'd0);
        check("R11 cfg_done reset", {31'd0, cfg_done}, 32'd0);
        check("R1 rd_valid idle", {31'd0, rd_valid}, 32'd0);
        rd_cur(IDB + 2, "R11 id after reset");
        rd(32'd2, 32'd640, "R11 width reset");
        rd(32'd3, 32'd480, "R11 height reset");
        rd(32'd4, 32'd32, "R11 bpp reset");
        rd(32'd1, 32'd0, "R11 enable reg reset");
        // R9 ring hidden before handshake
        rd(32'd9, 32'd0, "R9 ring base before handshake");
        // R3 handshake
        wr(32'd0, IDB + 7);
        rd(32'd0, IDB + 2, "R3 unsupported id kept old");
        wr(32'd0, IDB + 1);
        rd(32'd0, IDB + 1, "R3 supported id stored");
        rd(32'd9, 32'h0010_0000, "R9 ring base visible");
        rd(32'd10, 32'h0004_0000, "R9 ring size visible");
        wr(32'd0, IDB);
        rd(32'd0, IDB, "R3 legacy id stored");
        rd(32'd10, 32'd0, "R9 ring size hidden after legacy");
        wr(32'd0, IDB + 2);
        // R4 depth
        wr(32'd4, 32'd8);
        rd(32'd4, 32'd32, "R4 bpp read-only without capability");
        cap_vec = 32'h0000_0002;
        rd(32'd6, 32'h0000_0002, "R2 caps reflect input");
        wr(32'd4, 32'd16);
        rd(32'd4, 32'd32, "R4 bpp illegal value dropped");
        wr(32'd4, 32'd8);
        rd(32'd4, 32'd8, "R4 bpp 8 accepted");
        // R7 derived values
        rd(32'd7, 32'd640, "R7 pitch 640x8");
        rd(32'd8, 32'd1280, "R7 offset 640x8");
        wr(32'd2, 32'd1024);
        rd(32'd7, 32'd1024, "R7 pitch after width");
        wr(32'd4, 32'd32);
        rd(32'd7, 32'd4096, "R7 pitch after depth");
        rd(32'd8, 32'd8192, "R7 offset after depth");
        // R8 limits
        wr(32'd2, 32'd4000);
        rd(32'd2, 32'd1024, "R8 width over max ignored");
        wr(32'd2, 32'd2048);
        rd(32'd2, 32'd2048, "R8 width at max stored");
        wr(32'd3, 32'd2000);
        rd(32'd3, 32'd480, "R8 height over max ignored");
        wr(32'd3, 32'd600);
        rd(32'd3, 32'd600, "R2 height stored");
        // R5 / R6 flags
        wr(32'd1, 32'd1);
        check("R5 mode_en set", {31'd0, mode_en}, 32'd1);
        rd(32'd1, 32'd1, "R5 enable reads 1");
        wr(32'd11, 32'd1);
        check("R6 cfg_done set", {31'd0, cfg_done}, 32'd1);
        wr(32'd11, 32'd0);
        check("R6 cfg_done cleared", {31'd0, cfg_done}, 32'd0);
        rd(32'd11, 32'd0, "R6 go reads 0");
        // R10 unimplemented
        wr(32'd40, 32'hFFFF_FFFF);
        rd(32'd40, 32'd0, "R10 unimplemented reads 0");
        rd(32'd1, 32'd1, "R10 enable untouched");
        rd(32'd2, 32'd2048, "R10 width untouched");
        rd(32'd0, IDB + 2, "R10 id untouched");
        wr(32'd1, 32'd0);
        check("R5 mode_en cleared", {31'd0, mode_en}, 32'd0);
        // R1 selection persists over repeated reads
        rd_cur(32'd0, "R1 repeated read of held selection");
        repeat (3) @(negedge clk);
        check("R1 rd_valid idle at end", {31'd0, rd_valid}, 32'd0);
        if (exp_q.size() != 0) check("R1 outstanding reads", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule